// File: doc/BRIEF.md
# Issue Interlock Scoreboard

This block sits at the issue point of an in-order core whose integer and multiply pipes advance in lockstep beside a separate load/store pipe. Every cycle it looks at the instruction offered for issue and decides whether it may enter execution, or must be held because one of its source registers is still being computed by an earlier instruction. It records each accepted producer's destination registers together with a countdown that follows the producer's operation class.

A result can be ready at two different times. A consumer that needs the operand at the very start of execution has to wait longer than one that reads it a stage later. Shift amounts, multiplier inputs and store addresses are early reads. Ordinary ALU operands are late reads. Each source carries an early flag, and the block compares that source's register countdown against the threshold for its kind of read. The per-register countdowns and a busy mask are exported so that the surrounding pipeline can watch them.

Top module: `issue_interlock`

## Requirements
- R1: After reset, every register countdown is zero, the busy mask is clear, and `stall` is low while no instruction is offered.
- R2: Class codes 0 (ALU, no shifted operand) and 1 (ALU, immediate-shift operand) produce a result that an early reader may use 2 cycles after the producer issues and a late reader may use 1 cycle after it issues.
- R3: Class code 2 (ALU, register-specified shift) produces a result that is ready 3 cycles after issue for early readers and 2 cycles after issue for late readers.
- R4: Class code 3 (32x32 multiply) is ready at 4 early / 3 late. Class code 5 (16x16 multiply) is ready at 3 early / 2 late. Class code 4 (long multiply) is ready at 5 early / 4 late, and both destination slots are marked when both are valid.
- R5: Class code 6 (word load) is ready at 3 early / 2 late. Class code 7 (byte load) is ready at 4 early / 3 late. Class code 8 (multi-register load) is ready at 4 early / 3 late.
- R6: Class codes 9 (store), 10 (no result) and 11 to 15 never mark any register, even when the destination valid bits are set.
- R7: When the offered instruction is class 0, every source is treated as a late read, whatever its early flag says.
- R8: `stall` is high exactly when `iss_valid` is high and at least one source whose valid bit is set names a register that is not yet ready for that source's kind of read. Sources whose valid bit is clear have no effect.
- R9: While `stall` is high, the offered instruction marks no destination register.
- R10: Each nonzero countdown drops by one per cycle until it reaches zero. A register's busy bit is high while its countdown is nonzero.
- R11: A later accepted producer that names an already pending register replaces that register's countdown with its own latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_class | input | 4 | Operation class code of the offered instruction |
| src_vld | input | NSRC | Per-source valid bits |
| src_idx | input | NSRC*RW | Per-source register numbers; source s occupies bits [s*RW +: RW] |
| src_early | input | NSRC | Per-source early-read flags |
| dst_vld | input | 2 | Valid bits of the two destination slots |
| dst_idx | input | 2*RW | Destination register numbers; slot d occupies bits [d*RW +: RW] |
| stall | output | 1 | Hold the offered instruction this cycle |
| sb_busy | output | NREG | Per-register busy mask (countdown nonzero) |
| sb_count | output | NREG*CW | Per-register countdowns; register r occupies bits [r*CW +: CW] |

## Verification
The hardest situation to reach is a pending register that two different producers write over one another while a consumer waits behind a stall on a third register. This case needs an accepted issue, a held issue and a countdown replacement close together in time. The stimulus offers each consumer again, cycle after cycle, until a reference model that works from absolute ready times (issue cycle plus latency) says it may go. The stall from the model must match the design's stall on every offered cycle, and the busy mask must match it too, so every step of each countdown is compared. Back-to-back producers aimed at the same register check that the newer latency replaces the older one.

// File: rtl/ilk_pkg.sv
`timescale 1ns/1ps
package ilk_pkg;

   // longest early-read latency among all classes
   localparam int MAX_LAT = 5;
   localparam int NDST    = 2;

   typedef enum logic [3:0] {
      CLS_ALU     = 4'd0,
      CLS_ALU_SHI = 4'd1,
      CLS_ALU_SHR = 4'd2,
      CLS_MUL32   = 4'd3,
      CLS_MUL64   = 4'd4,
      CLS_MUL16   = 4'd5,
      CLS_LD_WORD = 4'd6,
      CLS_LD_BYTE = 4'd7,
      CLS_LD_MULT = 4'd8,
      CLS_STORE   = 4'd9,
      CLS_NONE    = 4'd10
   } op_class_e;

endpackage

// File: rtl/ilk_lat_decode.sv
`timescale 1ns/1ps
module ilk_lat_decode #(
   parameter int CW = 3
) (
   input  logic [3:0]    cls,
   output logic          writes,
   output logic [CW-1:0] load_val
);
   import ilk_pkg::*;

   logic [3:0] early_lat;

   always_comb begin
      writes    = 1'b1;
      early_lat = 4'd0;
      case (cls)
         CLS_ALU, CLS_ALU_SHI:         early_lat = 4'd2;
         CLS_ALU_SHR:                  early_lat = 4'd3;
         CLS_MUL32:                    early_lat = 4'd4;
         CLS_MUL64:                    early_lat = 4'd5;
         CLS_MUL16:                    early_lat = 4'd3;
         CLS_LD_WORD:                  early_lat = 4'd3;
         CLS_LD_BYTE, CLS_LD_MULT:     early_lat = 4'd4;
         default: begin
            writes    = 1'b0;
            early_lat = 4'd1;
         end
      endcase
   end

   // counter holds cycles still to wait for an early reader, minus one
   assign load_val = CW'(early_lat - 4'd1);

endmodule

// File: rtl/ilk_reg_timer.sv
`timescale 1ns/1ps
module ilk_reg_timer #(
   parameter int CW       = 3,
   parameter int MAX_LOAD = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   output logic [CW-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (ld)
         cnt <= ld_val;
      else if (cnt != '0)
         cnt <= cnt - CW'(1);
   end

   // R10
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(MAX_LOAD));

   // R10
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

   // R10
   cnt_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/ilk_src_check.sv
`timescale 1ns/1ps
module ilk_src_check #(
   parameter int CW          = 3,
   parameter bit LATE_RELIEF = 1'b1
) (
   input  logic          vld,
   input  logic          early,
   input  logic [CW-1:0] cnt,
   output logic          blocked
);

   logic not_ready;

   generate
      if (LATE_RELIEF) begin : g_two_point
         // late readers tolerate one more remaining cycle
         assign not_ready = early ? (cnt != '0) : (cnt > CW'(1));
      end else begin : g_one_point
         assign not_ready = (cnt != '0);
      end
   endgenerate

   assign blocked = vld & not_ready;

endmodule

// File: rtl/issue_interlock.sv
`timescale 1ns/1ps
module issue_interlock #(
   parameter int NREG        = 16,
   parameter int NSRC        = 3,
   parameter bit LATE_RELIEF = 1'b1,
   localparam int RW         = $clog2(NREG),
   localparam int CW         = $clog2(ilk_pkg::MAX_LAT)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 iss_valid,
   input  logic [3:0]           iss_class,
   input  logic [NSRC-1:0]      src_vld,
   input  logic [NSRC*RW-1:0]   src_idx,
   input  logic [NSRC-1:0]      src_early,
   input  logic [1:0]           dst_vld,
   input  logic [2*RW-1:0]      dst_idx,
   output logic                 stall,
   output logic [NREG-1:0]      sb_busy,
   output logic [NREG*CW-1:0]   sb_count
);
   import ilk_pkg::*;

   localparam int MAX_LOAD = MAX_LAT - 1;

   generate
      if (NREG < 2 || NREG != (1 << RW)) begin : g_bad_nreg
         $error("NREG must be a power of two, at least 2");
      end
      if (NSRC < 1) begin : g_bad_nsrc
         $error("NSRC must be at least 1");
      end
      if (MAX_LOAD >= (1 << CW)) begin : g_bad_cw
         $error("counter width too small for longest latency");
      end
   endgenerate

   logic          writes_w;
   logic [CW-1:0] load_val;
   logic          accept;
   logic          hazard;
   logic [CW-1:0] cnt_a   [NREG];
   logic [NSRC-1:0] blocked;

   ilk_lat_decode #(.CW(CW)) u_dec (
      .cls      (iss_class),
      .writes   (writes_w),
      .load_val (load_val)
   );

   assign accept = iss_valid & ~stall & writes_w;

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_reg
         logic hit;
         always_comb begin
            hit = 1'b0;
            for (int d = 0; d < NDST; d++)
               if (dst_vld[d] && dst_idx[d*RW +: RW] == RW'(r))
                  hit = 1'b1;
         end

         ilk_reg_timer #(.CW(CW), .MAX_LOAD(MAX_LOAD)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (accept & hit),
            .ld_val (load_val),
            .cnt    (cnt_a[r])
         );

         assign sb_busy[r]             = (cnt_a[r] != '0);
         assign sb_count[r*CW +: CW]   = cnt_a[r];
      end

      for (genvar s = 0; s < NSRC; s++) begin : g_src
         logic early_eff;
         // a plain ALU consumer never reads early
         assign early_eff = src_early[s] & (iss_class != CLS_ALU);

         ilk_src_check #(.CW(CW), .LATE_RELIEF(LATE_RELIEF)) u_chk (
            .vld     (src_vld[s]),
            .early   (early_eff),
            .cnt     (cnt_a[src_idx[s*RW +: RW]]),
            .blocked (blocked[s])
         );
      end
   endgenerate

   assign hazard = |blocked;
   assign stall  = iss_valid & hazard;

   // R8
   stall_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> iss_valid);

   // R9
   no_mark_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ((sb_busy & ~$past(sb_busy)) == '0));

   // R6
   no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !writes_w) |=> ((sb_busy & ~$past(sb_busy)) == '0));

   // R4
   long_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !stall && iss_class == CLS_MUL64 && dst_vld == 2'b11)
      |=> (sb_busy[$past(dst_idx[RW-1:0])] && sb_busy[$past(dst_idx[2*RW-1:RW])]));

endmodule

// File: tb/issue_interlock_test.sv
`timescale 1ns/1ps
module issue_interlock_test;

   localparam int NREG = 16;
   localparam int NSRC = 3;
   localparam int RW   = 4;
   localparam int CW   = 3;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                iss_valid;
   logic [3:0]          iss_class;
   logic [NSRC-1:0]     src_vld;
   logic [NSRC*RW-1:0]  src_idx;
   logic [NSRC-1:0]     src_early;
   logic [1:0]          dst_vld;
   logic [2*RW-1:0]     dst_idx;
   logic                stall;
   logic [NREG-1:0]     sb_busy;
   logic [NREG*CW-1:0]  sb_count;

   issue_interlock #(.NREG(NREG), .NSRC(NSRC)) uut (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
      .src_vld(src_vld), .src_idx(src_idx), .src_early(src_early),
      .dst_vld(dst_vld), .dst_idx(dst_idx), .stall(stall),
      .sb_busy(sb_busy), .sb_count(sb_count)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int fails  = 0;

   // reference: absolute edge from which each register is ready
   int rdy_e [NREG];
   int rdy_l [NREG];

   bit              q_st  [$];
   logic [NREG-1:0] q_bz  [$];
   string           q_tag [$];

   function automatic int early_lat(input int c);
      case (c)
         0, 1:    return 2;
         2:       return 3;
         3:       return 4;
         4:       return 5;
         5:       return 3;
         6:       return 3;
         7, 8:    return 4;
         default: return 0;
      endcase
   endfunction

   // one cycle of stimulus; acc reports whether the model accepts it
   task automatic present(input bit v, input int c,
                          input bit [2:0] sv, input int s0, input int s1, input int s2,
                          input bit [2:0] se, input bit [1:0] dv, input int d0, input int d1,
                          input string tag, output bit acc);
      int j;
      bit hz;
      int sr [3];
      logic [NREG-1:0] bz;
      @(negedge clk);
      iss_valid = v;
      iss_class = 4'(c);
      src_vld   = sv;
      src_idx   = {RW'(s2), RW'(s1), RW'(s0)};
      src_early = se;
      dst_vld   = dv;
      dst_idx   = {RW'(d1), RW'(d0)};
      sr[0] = s0; sr[1] = s1; sr[2] = s2;
      j  = cyc + 1;
      hz = 1'b0;
      for (int s = 0; s < 3; s++) begin
         if (sv[s]) begin
            bit ee;
            ee = se[s] && (c != 0);
            if (j < (ee ? rdy_e[sr[s]] : rdy_l[sr[s]])) hz = 1'b1;
         end
      end
      for (int r = 0; r < NREG; r++) bz[r] = (rdy_e[r] > cyc + 1);
      q_st.push_back(v & hz);
      q_bz.push_back(bz);
      q_tag.push_back(tag);
      acc = v & ~hz;
      if (acc && early_lat(c) > 0) begin
         if (dv[0]) begin rdy_e[d0] = j + early_lat(c); rdy_l[d0] = j + early_lat(c) - 1; end
         if (dv[1]) begin rdy_e[d1] = j + early_lat(c); rdy_l[d1] = j + early_lat(c) - 1; end
      end
   endtask

   task automatic idle(input string tag);
      bit a;
      present(1'b0, 10, 3'b000, 0, 0, 0, 3'b000, 2'b00, 0, 0, tag, a);
   endtask

   task automatic prod(input int c, input int d0, input string tag);
      bit a;
      present(1'b1, c, 3'b000, 0, 0, 0, 3'b000, 2'b01, d0, 0, tag, a);
   endtask

   // offer a single-source consumer until it is accepted
   task automatic wait_use(input int c, input int s, input bit early, input int d,
                           input string tag);
      bit a;
      a = 1'b0;
      for (int k = 0; k < 10 && !a; k++)
         present(1'b1, c, 3'b001, s, 0, 0, {2'b00, early}, 2'b01, d, 0, tag, a);
   endtask

   // monitor: compare against the queued expectation, away from the edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (q_st.size() > 0) begin
            bit              es;
            logic [NREG-1:0] eb;
            string           t;
            es = q_st.pop_front();
            eb = q_bz.pop_front();
            t  = q_tag.pop_front();
            checks++;
            if (stall !== es || sb_busy !== eb) begin
               fails++;
               $display("FAIL %s: stall=%b busy=%h, expected stall=%b busy=%h",
                        t, stall, sb_busy, es, eb);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      bit a;
      for (int r = 0; r < NREG; r++) begin rdy_e[r] = 0; rdy_l[r] = 0; end
      rst_n = 1'b0;
      iss_valid = 1'b0; iss_class = 4'd10; src_vld = '0; src_idx = '0;
      src_early = '0; dst_vld = '0; dst_idx = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      idle("R1");
      checks++;
      if (sb_count !== '0) begin
         fails++;
         $display("FAIL R1: count=%h, expected 0", sb_count);
      end

      // R2 shift-immediate reader, early operand: stalls one cycle
      prod(0, 1, "R2");
      wait_use(1, 1, 1'b1, 2, "R2");
      // R2 late reader right behind an ALU producer
      prod(1, 3, "R2");
      wait_use(1, 3, 1'b0, 4, "R2");
      // R7 plain ALU consumer with early flag still reads late
      prod(0, 2, "R7");
      wait_use(0, 2, 1'b1, 5, "R7");
      // R3 register-shift producer
      prod(2, 3, "R3");
      wait_use(1, 3, 1'b0, 6, "R3");
      prod(2, 3, "R3");
      wait_use(3, 3, 1'b1, 6, "R3");

      // R4 multiplies
      prod(3, 4, "R4");
      wait_use(3, 4, 1'b1, 7, "R4");
      present(1'b1, 4, 3'b000, 0, 0, 0, 3'b000, 2'b11, 5, 6, "R4", a);
      wait_use(1, 6, 1'b0, 8, "R4");
      wait_use(3, 5, 1'b1, 8, "R4");
      prod(5, 7, "R4");
      wait_use(1, 7, 1'b0, 9, "R4");

      // R5 loads
      prod(6, 8, "R5");
      wait_use(3, 8, 1'b1, 9, "R5");
      prod(7, 9, "R5");
      wait_use(1, 9, 1'b0, 10, "R5");
      prod(8, 10, "R5");
      wait_use(9, 10, 1'b1, 0, "R5");
      repeat (5) idle("R10");

      // R6 store and spare codes mark nothing
      prod(9, 11, "R6");
      idle("R6");
      prod(12, 11, "R6");
      idle("R6");
      present(1'b1, 10, 3'b000, 0, 0, 0, 3'b000, 2'b11, 11, 12, "R6", a);
      idle("R6");

      // R8 disabled sources and no issue do not stall
      prod(7, 12, "R8");
      present(1'b1, 3, 3'b110, 12, 0, 0, 3'b001, 2'b00, 0, 0, "R8", a);
      present(1'b0, 3, 3'b111, 12, 12, 12, 3'b111, 2'b00, 0, 0, "R8", a);
      present(1'b1, 1, 3'b100, 0, 0, 12, 3'b100, 2'b00, 0, 0, "R8", a);
      repeat (4) idle("R10");

      // R9 stalled producer marks nothing
      prod(7, 13, "R9");
      wait_use(3, 13, 1'b1, 14, "R9");
      repeat (5) idle("R10");

      // R11 newer producer replaces countdown
      present(1'b1, 4, 3'b000, 0, 0, 0, 3'b000, 2'b01, 15, 0, "R11", a);
      prod(0, 15, "R11");
      wait_use(1, 15, 1'b1, 1, "R11");
      // R11 longer producer replaces shorter
      prod(0, 2, "R11");
      prod(7, 2, "R11");
      wait_use(3, 2, 1'b1, 3, "R11");
      repeat (6) idle("R10");

      @(negedge clk);
      @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule